// File: doc/BRIEF.md
# Zero-Page and Stack Fast Memory

This block keeps the two lowest 256-byte pages of an 8-bit CPU's address space (page 0, used for pointers, and page 1, used for the stack) in two register files inside the core. Pointer fetches, pushes, pulls and return-address fetches are served from these files. At the same time, the rest of the address space is reached through a separate external write path.

Each file has two read ports and one write port. A single read request returns the addressed byte and the byte after it in one clock, so an indirect pointer or a return address arrives whole. The next-byte address wraps inside the same page. Writes go through a sequencer. A byte write completes in one clock. A 16-bit write occupies the single write port for two clocks: the high byte goes first, then the low byte.

Every address is decoded on its high byte, so every addressing mode, including absolute and indexed forms, reaches the same internal copy of pages 0 and 1. A parameter selects the file organisation. The first option is a plain two-read-port array per page. The second splits each page into an even bank and an odd bank, so that any two neighbouring bytes read together.

Top module: `zp_stack_mem`

## Requirements
- R1: While reset is active and in the first clock after it, `wr_ready_o` is 1 and `ext_wr_en_o` is 0 when no write is requested.
- R2: For a read address whose high byte is $00 or $01, `rd_int_o` is 1 in the same clock. `rd_data_o[7:0]` holds the byte at the address, and `rd_data_o[15:8]` holds the byte at the next address in the same page.
- R3: The second byte of a read wraps inside its page: a read at $00FF takes its high byte from $0000, and a read at $01FF takes it from $0100.
- R4: Page 0 and page 1 are separate storage. A write to $00nn leaves $01nn unchanged, and the reverse also holds. Any access with high byte $00 reaches the same location as an access with only the low byte.
- R5: For an address whose high byte is neither $00 nor $01, a read gives `rd_int_o`=0 and `rd_data_o`=0. A byte write to such an address appears on `ext_wr_en_o`, `ext_wr_addr_o` and `ext_wr_data_o` in the same clock and changes no internal byte.
- R6: An internal byte written in one clock is returned by reads from the next clock on. A read of that location in the same clock as the write returns the old value.
- R7: A 16-bit write request (`wr_wide_i`=1) with address A writes `wr_data_i[15:8]` to the next address after A in A's page in the first clock. It writes `wr_data_i[7:0]` to A in the second clock. `wr_ready_o` is 0 during the second clock only. A byte request (`wr_wide_i`=0) writes `wr_data_i[7:0]` to A in one clock.
- R8: A write request presented while `wr_ready_o` is 0 is ignored.
- R9: The even/odd banked organisation (`BANKED`=1) gives port behaviour identical to the plain organisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_addr_i | input | ADDR_W | Read address (first byte) |
| rd_data_o | output | 2*DATA_W | {next byte, addressed byte}; 0 when not internal |
| rd_int_o | output | 1 | Read address lies in page 0 or 1 |
| wr_req_i | input | 1 | Write request |
| wr_wide_i | input | 1 | Request is a 16-bit write |
| wr_addr_i | input | ADDR_W | Write address (low byte location) |
| wr_data_i | input | 2*DATA_W | Write data; low byte in [7:0] |
| wr_ready_o | output | 1 | Sequencer accepts a request this clock |
| ext_wr_en_o | output | 1 | Byte write to external memory this clock |
| ext_wr_addr_o | output | ADDR_W | External write address |
| ext_wr_data_o | output | DATA_W | External write byte |

## Verification
The hardest situation to reach is a 16-bit write whose second half collides with other traffic. This happens when the high byte wraps to the start of the page, a new request arrives during the busy clock, and a read of the very byte being written falls in the same clock. Directed steps write a word at $01FF and issue a request during the busy clock. They also read the target bytes in the write clock and the clock after it. A long stretch of random traffic, biased toward pages 0 and 1 and toward page-end addresses, then checks a plain behavioural model against both file organisations on every clock.

// File: rtl/zsm_pkg.sv
package zsm_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_LOW = 1'b1} seq_state_e;
endpackage

// File: rtl/zsm_decode.sv
module zsm_decode #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pg0_o,
  output logic              pg1_o,
  output logic              ext_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int PG_W = ADDR_W - IDX_W;
  logic [PG_W-1:0] page;
  assign page  = addr_i[ADDR_W-1:IDX_W];
  assign idx_o = addr_i[IDX_W-1:0];
  assign pg0_o = (page == PG_W'(0));
  assign pg1_o = (page == PG_W'(1));
  assign ext_o = !(pg0_o || pg1_o);
endmodule

// File: rtl/zsm_file.sv
module zsm_file #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter bit BANKED = 1'b0
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HALF  = DEPTH / 2;
  localparam int HW    = IDX_W - 1;

  logic [IDX_W-1:0] raddr_nx;
  assign raddr_nx = raddr_i + IDX_W'(1);  // wraps inside the page

  if (!BANKED) begin : g_flat
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i;
    end
    assign lo_o = mem[raddr_i];
    assign hi_o = mem[raddr_nx];
  end else begin : g_banked
    logic [DATA_W-1:0] even_q [HALF];
    logic [DATA_W-1:0] odd_q  [HALF];
    logic [HW-1:0]     e_idx, o_idx;
    logic [DATA_W-1:0] e_dat, o_dat;
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i[0])  odd_q[waddr_i[IDX_W-1:1]]  <= wdata_i;
      if (we_i && !waddr_i[0]) even_q[waddr_i[IDX_W-1:1]] <= wdata_i;
    end
    // one read per bank: an odd start takes its partner from the next even slot
    assign e_idx = raddr_i[0] ? raddr_nx[IDX_W-1:1] : raddr_i[IDX_W-1:1];
    assign o_idx = raddr_i[IDX_W-1:1];
    assign e_dat = even_q[e_idx];
    assign o_dat = odd_q[o_idx];
    assign lo_o  = raddr_i[0] ? o_dat : e_dat;
    assign hi_o  = raddr_i[0] ? e_dat : o_dat;
  end
endmodule

// File: rtl/zsm_wr_seq.sv
module zsm_wr_seq
  import zsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                wide_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DATA_W-1:0] data_i,
  output logic                ready_o,
  output logic                wb_en_o,
  output logic [ADDR_W-1:0]   wb_addr_o,
  output logic [DATA_W-1:0]   wb_data_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [ADDR_W-1:0] addr_nx;
  logic              take_wide;

  assign addr_nx   = {addr_i[ADDR_W-1:IDX_W], addr_i[IDX_W-1:0] + IDX_W'(1)};
  assign ready_o   = (state_q == SEQ_IDLE);
  assign take_wide = ready_o && req_i && wide_i;

  always_comb begin
    if (!ready_o) begin
      wb_en_o   = 1'b1;
      wb_addr_o = pend_addr_q;
      wb_data_o = pend_data_q;
    end else begin
      wb_en_o   = req_i;
      wb_addr_o = wide_i ? addr_nx : addr_i;
      wb_data_o = wide_i ? data_i[2*DATA_W-1:DATA_W] : data_i[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      state_q <= take_wide ? SEQ_LOW : SEQ_IDLE;
      if (take_wide) begin
        pend_addr_q <= addr_i;
        pend_data_q <= data_i[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/zp_stack_mem.sv
module zp_stack_mem #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter bit BANKED = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [2*DATA_W-1:0] rd_data_o,
  output logic                rd_int_o,
  input  logic                wr_req_i,
  input  logic                wr_wide_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [2*DATA_W-1:0] wr_data_i,
  output logic                wr_ready_o,
  output logic                ext_wr_en_o,
  output logic [ADDR_W-1:0]   ext_wr_addr_o,
  output logic [DATA_W-1:0]   ext_wr_data_o
);
  localparam int NPG = 2;

  logic              rd_pg0, rd_pg1, rd_ext;
  logic [IDX_W-1:0]  rd_idx;
  logic              wb_en;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic              wb_pg0, wb_pg1, wb_ext;
  logic [IDX_W-1:0]  wb_idx;
  logic [NPG-1:0]    pg_we;
  logic [DATA_W-1:0] pg_lo [NPG];
  logic [DATA_W-1:0] pg_hi [NPG];

  zsm_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_rd_dec (
    .addr_i(rd_addr_i), .pg0_o(rd_pg0), .pg1_o(rd_pg1), .ext_o(rd_ext), .idx_o(rd_idx)
  );

  zsm_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_seq (
    .clk_i, .rst_ni,
    .req_i(wr_req_i), .wide_i(wr_wide_i), .addr_i(wr_addr_i), .data_i(wr_data_i),
    .ready_o(wr_ready_o), .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  zsm_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_wr_dec (
    .addr_i(wb_addr), .pg0_o(wb_pg0), .pg1_o(wb_pg1), .ext_o(wb_ext), .idx_o(wb_idx)
  );

  assign pg_we = {wb_en && wb_pg1, wb_en && wb_pg0};

  for (genvar p = 0; p < NPG; p++) begin : g_page
    zsm_file #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BANKED(BANKED)) i_file (
      .clk_i, .we_i(pg_we[p]), .waddr_i(wb_idx), .wdata_i(wb_data),
      .raddr_i(rd_idx), .lo_o(pg_lo[p]), .hi_o(pg_hi[p])
    );
  end

  assign rd_int_o = !rd_ext;
  always_comb begin
    if (rd_pg0)      rd_data_o = {pg_hi[0], pg_lo[0]};
    else if (rd_pg1) rd_data_o = {pg_hi[1], pg_lo[1]};
    else             rd_data_o = '0;
  end

  assign ext_wr_en_o   = wb_en && wb_ext;
  assign ext_wr_addr_o = wb_addr;
  assign ext_wr_data_o = wb_data;
endmodule

// File: rtl/zsm_checker.sv
module zsm_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   rd_addr_i,
  input logic [2*DATA_W-1:0] rd_data_o,
  input logic                rd_int_o,
  input logic                wr_req_i,
  input logic                wr_wide_i,
  input logic                wr_ready_o,
  input logic                ext_wr_en_o,
  input logic                wb_en,
  input logic [1:0]          pg_we,
  input logic [IDX_W-1:0]    wb_idx,
  input logic [DATA_W-1:0]   wb_data
);
  localparam int PG_W = ADDR_W - IDX_W;

  a_r7_busy_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> wr_ready_o);

  a_r7_wide_enters_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && wr_wide_i && wr_ready_o) |=> !wr_ready_o);

  a_r8_busy_writes_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |-> wb_en);

  a_r5_ext_not_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_en_o |-> (pg_we == 2'b00));

  a_r5_ext_read_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i[ADDR_W-1:IDX_W] > PG_W'(1)) |-> (!rd_int_o && rd_data_o == '0));

  a_r6_next_clock_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pg_we[0]) && rd_addr_i[ADDR_W-1:IDX_W] == PG_W'(0) &&
     rd_addr_i[IDX_W-1:0] == $past(wb_idx)) |-> rd_data_o[DATA_W-1:0] == $past(wb_data));
endmodule

bind zp_stack_mem zsm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_zsm_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .rd_int_o(rd_int_o), .wr_req_i(wr_req_i), .wr_wide_i(wr_wide_i),
  .wr_ready_o(wr_ready_o), .ext_wr_en_o(ext_wr_en_o), .wb_en(wb_en),
  .pg_we(pg_we), .wb_idx(wb_idx), .wb_data(wb_data)
);

// File: tb/test_zp_stack_mem.sv
module test_zp_stack_mem;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rd_addr_i = '0;
  logic        wr_req_i = 1'b0, wr_wide_i = 1'b0;
  logic [15:0] wr_addr_i = '0, wr_data_i = '0;

  logic [15:0] rd_data_a, rd_data_b;
  logic        rd_int_a, rd_int_b, rdy_a, rdy_b, xen_a, xen_b;
  logic [15:0] xad_a, xad_b;
  logic [7:0]  xdt_a, xdt_b;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  zp_stack_mem #(.BANKED(1'b0)) i_zp_stack_mem (
    .clk_i, .rst_ni, .rd_addr_i, .rd_data_o(rd_data_a), .rd_int_o(rd_int_a),
    .wr_req_i, .wr_wide_i, .wr_addr_i, .wr_data_i, .wr_ready_o(rdy_a),
    .ext_wr_en_o(xen_a), .ext_wr_addr_o(xad_a), .ext_wr_data_o(xdt_a)
  );

  zp_stack_mem #(.BANKED(1'b1)) i_zp_stack_mem_bk (
    .clk_i, .rst_ni, .rd_addr_i, .rd_data_o(rd_data_b), .rd_int_o(rd_int_b),
    .wr_req_i, .wr_wide_i, .wr_addr_i, .wr_data_i, .wr_ready_o(rdy_b),
    .ext_wr_en_o(xen_b), .ext_wr_addr_o(xad_b), .ext_wr_data_o(xdt_b)
  );

  // reference model
  logic [7:0]  mdl [512];
  bit          pend = 0;
  logic [15:0] pend_addr;
  logic [7:0]  pend_data;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [15:0] nxt(logic [15:0] a);
    return {a[15:8], a[7:0] + 8'd1};
  endfunction

  function automatic bit is_int(logic [15:0] a);
    return a[15:9] == 7'd0;
  endfunction

  // inputs are set at the falling edge, outputs checked 1 ns later, model advanced at the rising edge
  task automatic step(bit req, bit wide, logic [15:0] wa, logic [15:0] wd, logic [15:0] ra);
    bit          ben;
    logic [15:0] baddr;
    logic [7:0]  bdata;
    logic [15:0] exp_rd;
    string       rtag;
    wr_req_i = req; wr_wide_i = wide; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    #1;
    if (pend) begin
      ben = 1; baddr = pend_addr; bdata = pend_data;
    end else begin
      ben = req; baddr = wide ? nxt(wa) : wa; bdata = wide ? wd[15:8] : wd[7:0];
    end
    if (!is_int(ra)) begin
      rtag = "R5"; exp_rd = 16'h0;
    end else begin
      exp_rd = {mdl[{ra[8], ra[7:0] + 8'd1}], mdl[ra[8:0]]};
      if (ben && is_int(baddr) && (baddr == ra || baddr == nxt(ra))) rtag = "R6";
      else if (ra[7:0] == 8'hFF) rtag = "R3";
      else if (ra[8]) rtag = "R4";
      else rtag = "R2";
    end
    chk({rtag, " rd_data"}, rd_data_a, exp_rd);
    chk({rtag, " rd_int"}, rd_int_a, is_int(ra));
    chk("R9 rd_data banked", rd_data_b, exp_rd);
    chk(pend && req ? "R8 ready" : "R7 ready", rdy_a, !pend);
    chk("R9 ready banked", rdy_b, !pend);
    chk("R5 ext_en", xen_a, ben && !is_int(baddr));
    chk("R9 ext_en banked", xen_b, ben && !is_int(baddr));
    if (ben && !is_int(baddr)) begin
      chk("R5 ext_addr", xad_a, baddr);
      chk("R5 ext_data", xdt_a, bdata);
    end
    @(posedge clk_i);
    if (ben && is_int(baddr)) mdl[baddr[8:0]] = bdata;
    if (pend) pend = 0;
    else if (req && wide) begin
      pend = 1; pend_addr = wa; pend_data = wd[7:0];
    end
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 ready in reset", rdy_a, 1);
    chk("R1 ext_en in reset", xen_a, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R1 ready after reset", rdy_a, 1);
    chk("R1 ext_en after reset", xen_a, 0);
    @(negedge clk_i);

    // fill both pages (R2 background)
    for (int i = 0; i < 512; i++)
      step(1, 0, 16'(i), 16'((i * 37 + 11) & 8'hFF), 16'h2000);

    // R3 wrap reads
    step(0, 0, 0, 0, 16'h00FF);
    step(0, 0, 0, 0, 16'h01FF);
    // R6 same-clock old value, next clock new value
    step(1, 0, 16'h0010, 16'h00A5, 16'h0010);
    step(0, 0, 0, 0, 16'h0010);
    // R4 pages separate; absolute $0110 vs $0010
    step(1, 0, 16'h0110, 16'h005A, 16'h0010);
    step(0, 0, 0, 0, 16'h0110);
    // R7 wide write wrapping at the stack page end, R8 request during busy ignored
    step(1, 1, 16'h01FF, 16'hBEEF, 16'h01FF);
    step(1, 0, 16'h0100, 16'h0077, 16'h01FF);
    step(0, 0, 0, 0, 16'h01FF);
    // R5 external byte and wide writes, external read
    step(1, 0, 16'h2345, 16'h00C3, 16'h8000);
    step(1, 1, 16'h40FF, 16'h1234, 16'hFFFF);
    step(0, 0, 0, 0, 16'h0200);
    // R7 wide write in zero page, read back
    step(1, 1, 16'h0040, 16'hCAFE, 16'h0040);
    step(0, 0, 0, 0, 16'h0040);
    step(0, 0, 0, 0, 16'h0040);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] wa, ra;
      int sel;
      sel = $urandom_range(0, 9);
      wa  = (sel < 4) ? {8'h00, 8'($urandom)} : (sel < 8) ? {8'h01, 8'($urandom)} : 16'($urandom);
      if ($urandom_range(0, 7) == 0) wa[7:0] = 8'hFF;
      sel = $urandom_range(0, 9);
      ra  = (sel < 4) ? {8'h00, 8'($urandom)} : (sel < 8) ? {8'h01, 8'($urandom)} : 16'($urandom);
      if ($urandom_range(0, 3) == 0) ra = wa;
      if ($urandom_range(0, 7) == 0) ra[7:0] = 8'hFF;
      step($urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0, wa, 16'($urandom), ra);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule